// File: doc/BRIEF.md
# Multi-Mode Camera Trigger Generator

The block generates eight trigger lines, six for cameras and two auxiliary, from one shared trigger engine. A mode register picks how the lines behave: held low, a repeating pulse train, one single pulse, held high, a pulse train that visits one line at a time, or a copy of one of two external inputs. An eight-bit enable mask decides which lines take part in any mode. Pulse width and repeat period are given in milliseconds and counted on a one-cycle tick that a prescaler derives from the system clock.

A second eight-bit register drives eight reset lines directly, with no sequencing. All configuration arrives on a synchronous write port: a 3-bit address, an 8-bit data bus and a write strobe. Writing the mode register, even with its current value, restarts the pulse counters. The engine then begins a fresh pulse on the next millisecond tick.

Top module: `cam_trig_gen`

## Requirements
- R1: A trigger output is driven high only if its bit in the enable mask (address 1, bit i gates output i) is set. Unmasked outputs stay low in every mode.
- R2: Writing mode 0 (stop) to address 0 drives all trigger outputs low in the cycle after the write. They stay low while the mode is 0.
- R3: In mode 1 (interval), each enabled output is high for exactly width ms (address 2). The time from one rising edge to the next is exactly period ms (address 3). One ms is CLK_HZ/TICK_HZ clock cycles, and outputs change only on a tick.
- R4: A programmed width or period of zero behaves as 1 ms.
- R5: When the effective width is at least the effective period, interval mode keeps the enabled outputs high without a gap.
- R6: In mode 2 (oneshot), one pulse of width ms is emitted on the enabled outputs. The outputs then stay low until the mode is written again.
- R7: In mode 3 (constant), the trigger outputs equal the enable mask, starting the cycle after the write and following later mask writes.
- R8: In mode 4 (round-robin), pulses use interval timing, and at most one output is high at any time. The first pulse after the mode write goes to the lowest enabled output. Each following pulse goes to the next enabled output in ascending order, wrapping from 7 to 0 and skipping disabled outputs.
- R9: In round-robin mode with an all-zero mask, no trigger output goes high.
- R10: In mode 5 (follower), all enabled outputs copy auxiliary input 0 or 1, chosen by bit 0 of address 4. The input passes through two flops, so a change at an input shows on the outputs after the second rising clock edge.
- R11: Writing address 5 sets the eight reset outputs to the written byte in the cycle after the write.
- R12: After reset, all trigger and reset outputs are low and the mode is stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 mode, 1 mask, 2 width, 3 period, 4 follower select, 5 reset lines |
| wr_data_i | input | 8 | Write data |
| aux_in_i | input | 2 | Asynchronous auxiliary inputs for follower mode |
| trig_o | output | 8 | Trigger outputs; bits 0-5 cameras, bits 6-7 auxiliary |
| rst_o | output | 8 | Reset outputs, driven straight from the reset register |

## Verification
The hardest situation to reach from the ports is the round-robin step across disabled outputs, including the wrap from output 6 back to output 0. The pointer is internal, so its order shows only through the sequence of one-hot pulses. The stimulus enables a sparse mask (outputs 0, 2 and 6) with a 1 ms width and a 2 ms period. It then records which line rises at each of four consecutive pulse starts, so both the skip and the wrap appear within 8 ms. Pulse width and period are checked by counting cycles between edges, which makes the checks independent of the prescaler phase at the time of the mode write.

// File: rtl/cam_trig_pkg.sv
package cam_trig_pkg;
  typedef enum logic [2:0] {
    MODE_STOP     = 3'd0,
    MODE_INTERVAL = 3'd1,
    MODE_ONESHOT  = 3'd2,
    MODE_CONST    = 3'd3,
    MODE_RROBIN   = 3'd4,
    MODE_FOLLOW   = 3'd5
  } trig_mode_e;

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_MASK   = 3'd1;
  localparam logic [2:0] ADDR_WIDTH  = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_FSEL   = 3'd4;
  localparam logic [2:0] ADDR_RESET  = 3'd5;
endpackage

// File: rtl/cam_trig_tick.sv
module cam_trig_tick #(
  parameter int DIV = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/cam_trig_sync.sv
module cam_trig_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cam_trig_rr.sv
module cam_trig_rr #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] cur_i,
  output logic [IW-1:0] nxt_o,
  output logic          any_o
);
  logic found;

  // next enabled index strictly after cur_i, wrapping
  always_comb begin
    nxt_o = cur_i;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(cur_i) + k) % N;
      if (!found && mask_i[idx]) begin
        nxt_o = IW'(idx);
        found = 1'b1;
      end
    end
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/cam_trig_seq.sv
module cam_trig_seq
  import cam_trig_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  trig_mode_e    mode_i,
  input  logic [TW-1:0] wid_i,
  input  logic [TW-1:0] per_i,
  input  logic [N-1:0]  mask_i,
  output logic          pulse_o,
  output logic [IW-1:0] ptr_o
);
  logic [TW-1:0] wid_e, per_e, cnt_q;
  logic          run_q, done_q;
  logic [IW-1:0] ptr_q, rr_cur, rr_nxt;
  logic          rr_any, timed, is_rr, wrap;
  logic [TW:0]   cnt_inc;

  assign wid_e   = (wid_i == '0) ? TW'(1) : wid_i;
  assign per_e   = (per_i == '0) ? TW'(1) : per_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = (cnt_inc >= {1'b0, per_e});
  assign is_rr   = (mode_i == MODE_RROBIN);
  assign timed   = (mode_i == MODE_INTERVAL) || (mode_i == MODE_ONESHOT) || is_rr;
  // before the first pulse, search from the top so the lowest enabled line wins
  assign rr_cur  = run_q ? ptr_q : IW'(N - 1);

  cam_trig_rr #(.N(N), .IW(IW)) u_rr (
    .mask_i (mask_i),
    .cur_i  (rr_cur),
    .nxt_o  (rr_nxt),
    .any_o  (rr_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else if (restart_i) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_i && timed && !done_q) begin
      if (!run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        if (is_rr && rr_any) ptr_q <= rr_nxt;
      end else if (mode_i == MODE_ONESHOT) begin
        if (cnt_inc >= {1'b0, wid_e}) done_q <= 1'b1;
        else                          cnt_q  <= cnt_inc[TW-1:0];
      end else if (wrap) begin
        cnt_q <= '0;
        if (is_rr && rr_any) ptr_q <= rr_nxt;
      end else begin
        cnt_q <= cnt_inc[TW-1:0];
      end
    end
  end

  assign pulse_o = run_q && !done_q && (cnt_q < wid_e);
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/cam_trig_gen.sv
module cam_trig_gen
  import cam_trig_pkg::*;
#(
  parameter int CLK_HZ  = 12_000_000,
  parameter int TICK_HZ = 1000,
  parameter int DW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    aux_in_i,
  output logic [DW-1:0] trig_o,
  output logic [DW-1:0] rst_o
);
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int N   = DW;
  localparam int IW  = $clog2(N);

  trig_mode_e    mode_q;
  logic [N-1:0]  mask_q, rst_q;
  logic [DW-1:0] wid_q, per_q;
  logic          fsel_q, tick, restart, pulse;
  logic [1:0]    aux_s;
  logic [IW-1:0] ptr;

  assign restart = wr_en_i && (wr_addr_i == ADDR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STOP;
      mask_q <= '0;
      wid_q  <= '0;
      per_q  <= '0;
      fsel_q <= 1'b0;
      rst_q  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MODE:   mode_q <= trig_mode_e'(wr_data_i[2:0]);
        ADDR_MASK:   mask_q <= wr_data_i;
        ADDR_WIDTH:  wid_q  <= wr_data_i;
        ADDR_PERIOD: per_q  <= wr_data_i;
        ADDR_FSEL:   fsel_q <= wr_data_i[0];
        ADDR_RESET:  rst_q  <= wr_data_i;
        default: ;
      endcase
    end
  end

  cam_trig_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  cam_trig_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (aux_in_i),
    .q_o    (aux_s)
  );

  cam_trig_seq #(.N(N), .TW(DW), .IW(IW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (restart),
    .mode_i    (mode_q),
    .wid_i     (wid_q),
    .per_i     (per_q),
    .mask_i    (mask_q),
    .pulse_o   (pulse),
    .ptr_o     (ptr)
  );

  always_comb begin
    unique case (mode_q)
      MODE_INTERVAL,
      MODE_ONESHOT: trig_o = pulse ? mask_q : '0;
      MODE_CONST:   trig_o = mask_q;
      MODE_RROBIN:  trig_o = pulse ? (mask_q & (N'(1) << ptr)) : '0;
      MODE_FOLLOW:  trig_o = {N{aux_s[fsel_q]}} & mask_q;
      default:      trig_o = '0;
    endcase
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/cam_trig_gen_chk.sv
module cam_trig_gen_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [2:0]   wr_addr_i,
  input logic [N-1:0] wr_data_i,
  input logic [N-1:0] trig_o,
  input logic [N-1:0] rst_o,
  input logic [N-1:0] mask_q,
  input logic [2:0]   mode_q,
  input logic         tick
);
  AST_MASK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o & ~mask_q) == '0);  // R1

  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && wr_data_i[2:0] == 3'd0) |=> (trig_o == '0));  // R2

  AST_INTERVAL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd1 && $past(mode_q) == 3'd1 && !$past(wr_en_i) && trig_o != $past(trig_o))
      |-> $past(tick));  // R3

  AST_RR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd4) |-> $onehot0(trig_o));  // R8

  AST_RST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd5) |=> (rst_o == $past(wr_data_i)));  // R11

  AST_CONST_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && wr_data_i[2:0] == 3'd3) |=> (trig_o == mask_q));  // R7
endmodule

bind cam_trig_gen cam_trig_gen_chk #(.N(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .trig_o    (trig_o),
  .rst_o     (rst_o),
  .mask_q    (mask_q),
  .mode_q    (mode_q),
  .tick      (tick)
);

// File: tb/cam_trig_gen_tb.sv
`timescale 1ns/1ps
module cam_trig_gen_tb_top;
  localparam int MS = 4;  // clock cycles per ms in this bench

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] aux = '0;
  logic [7:0] trig, rsto;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  cam_trig_gen #(.CLK_HZ(4000), .TICK_HZ(1000), .DW(8)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .aux_in_i  (aux),
    .trig_o    (trig),
    .rst_o     (rsto)
  );

  // mask, width, period, observed bit, expected high ms, expected period ms
  localparam logic [47:0] VEC [4] = '{
    48'h01_03_05_00_03_05,
    48'h40_02_04_06_02_04,
    48'h81_00_03_07_01_03,  // zero width -> 1 ms (R4)
    48'h0A_01_02_03_01_02
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(input int b, output bit seen);
    logic prev;
    prev = trig[b];
    seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && trig[b]) begin seen = 1'b1; break; end
      prev = trig[b];
    end
  endtask

  task automatic measure(input int b, input logic [7:0] m, output int hi, output int pe, output int leak);
    bit seen;
    hi = 0; pe = 0; leak = 0;
    wait_rise(b, seen);
    if (!seen) return;
    while (trig[b] && hi < 4000) begin
      if ((trig & ~m) != 0) leak++;
      hi++; @(negedge clk);
    end
    pe = hi;
    while (!trig[b] && pe < 4000) begin
      if ((trig & ~m) != 0) leak++;
      pe++; @(negedge clk);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int hi, pe, leak, bad;
    bit seen;
    logic [7:0] seq [4];
    logic [7:0] exp_seq [4];
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(trig == 8'h00, "R12 trig after reset", trig, 0);
    check(rsto == 8'h00, "R12 rst after reset", rsto, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: interval timing (R3, R4, R1)
    foreach (VEC[i]) begin
      logic [47:0] v;
      v = VEC[i];
      wr(3'd0, 8'd0);
      wr(3'd1, v[47:40]);
      wr(3'd2, v[39:32]);
      wr(3'd3, v[31:24]);
      wr(3'd0, 8'd1);
      measure(int'(v[23:16]), v[47:40], hi, pe, leak);
      check(hi == int'(v[15:8]) * MS, "R3 pulse width cycles", hi, int'(v[15:8]) * MS);
      check(pe == int'(v[7:0]) * MS, "R3 period cycles", pe, int'(v[7:0]) * MS);
      check(leak == 0, "R1 unmasked output high", leak, 0);
    end

    // R5: width >= period, and R4 zero width/period
    wr(3'd0, 8'd0); wr(3'd1, 8'h01); wr(3'd2, 8'd5); wr(3'd3, 8'd2); wr(3'd0, 8'd1);
    repeat (2 * MS) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 10 * MS; i++) begin @(negedge clk); if (trig != 8'h01) bad++; end
    check(bad == 0, "R5 width>=period held high", bad, 0);
    wr(3'd2, 8'd0); wr(3'd3, 8'd0); wr(3'd0, 8'd1);
    repeat (2 * MS) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 10 * MS; i++) begin @(negedge clk); if (trig != 8'h01) bad++; end
    check(bad == 0, "R4 zero width and period held high", bad, 0);

    // R6: oneshot
    wr(3'd0, 8'd0); wr(3'd1, 8'h02); wr(3'd2, 8'd4); wr(3'd3, 8'd6); wr(3'd0, 8'd2);
    measure(1, 8'h02, hi, pe, leak);
    check(hi == 4 * MS, "R6 oneshot width", hi, 4 * MS);
    bad = 0;
    for (int i = 0; i < 25 * MS; i++) begin @(negedge clk); if (trig != 8'h00) bad++; end
    check(bad == 0, "R6 oneshot no repeat", bad, 0);

    // R7 constant, R2 stop
    wr(3'd1, 8'h3C); wr(3'd0, 8'd3);
    check(trig == 8'h3C, "R7 constant equals mask", trig, 8'h3C);
    wr(3'd1, 8'h0F);
    check(trig == 8'h0F, "R7 constant follows mask", trig, 8'h0F);
    wr(3'd0, 8'd0);
    check(trig == 8'h00, "R2 stop clears outputs", trig, 0);
    repeat (5 * MS) @(negedge clk);
    check(trig == 8'h00, "R2 stop stays low", trig, 0);

    // R8: round-robin over outputs 0,2,6 with skip and wrap
    exp_seq = '{8'h01, 8'h04, 8'h40, 8'h01};
    wr(3'd1, 8'h45); wr(3'd2, 8'd1); wr(3'd3, 8'd2); wr(3'd0, 8'd4);
    prev = trig;
    for (int n = 0; n < 4; n++) begin
      seq[n] = 8'h00;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if (prev == 8'h00 && trig != 8'h00) begin seq[n] = trig; prev = trig; break; end
        prev = trig;
      end
      check(seq[n] == exp_seq[n], "R8 round-robin order", seq[n], exp_seq[n]);
    end

    // R9: round-robin with empty mask
    wr(3'd0, 8'd0); wr(3'd1, 8'h00); wr(3'd0, 8'd4);
    bad = 0;
    for (int i = 0; i < 10 * MS; i++) begin @(negedge clk); if (trig != 8'h00) bad++; end
    check(bad == 0, "R9 empty mask silent", bad, 0);

    // R10: follower with select and two-flop latency
    wr(3'd1, 8'hF0); wr(3'd4, 8'd1); wr(3'd0, 8'd5);
    aux = 2'b10;
    @(negedge clk);
    check(trig == 8'h00, "R10 sync latency first edge", trig, 0);
    @(negedge clk);
    check(trig == 8'hF0, "R10 follow aux1 high", trig, 8'hF0);
    aux = 2'b01;
    repeat (3) @(negedge clk);
    check(trig == 8'h00, "R10 aux0 ignored when aux1 selected", trig, 0);
    wr(3'd4, 8'd0);
    check(trig == 8'hF0, "R10 follow aux0", trig, 8'hF0);

    // R11: reset register
    wr(3'd5, 8'hC5);
    check(rsto == 8'hC5, "R11 reset lines loaded", rsto, 8'hC5);
    check(trig == 8'hF0, "R11 reset write leaves triggers", trig, 8'hF0);

    report();
  end
endmodule